// File: doc/BRIEF.md
# Triggered DMA Channel Sequencer

This block is the control and sequencing logic of one DMA channel. Software programs a word count, a source address and a destination address, then writes a 16-bit control word. The control word enables the channel, picks what starts it, and sets repeat, interrupt, address-hold and cartridge-request behaviour. Once started, the channel copies words one at a time. It reads a word through a request/acknowledge read port and then writes it through a request/acknowledge write port, until the count is used up.

The start source is one of four: right away, a rising edge of horizontal blank, a rising edge of vertical blank, or a rising edge of a per-channel special request. At the end of a run the channel either clears its own enable bit or stays armed for the next trigger. A control write that disables the channel in the same cycle as a trigger always resolves to a clean idle channel, and the channel never hangs. A disable written during a run stops the channel at the next word boundary.

Top module: `dma_channel`

## Requirements
- R1: While reset is high and in the first cycle after it, the control readback is 0, busy and the interrupt are low, and neither memory request is asserted.
- R2: A run moves N words, where N is the latched count, and a count of 0 means 2^CNT_W. Word k is read from source+k and written to destination+k. Control bit 6 set holds the source address fixed, and bit 7 set holds the destination fixed. Each written word equals the word read for it. A request holds its address and data steady until it is acknowledged, and reads and writes are never requested together.
- R3: Control bit 0 is the enable, bits 2:1 the start timing and bit 3 the repeat flag. A run that ends with timing 00 or with repeat clear leaves bit 0 at 0. No further run starts until software enables the channel again.
- R4: Timing 00 starts a run in the cycle after the enabling write. Timing 01 waits for a rising edge of horizontal blank, 10 for vertical blank, and 11 for the special request (absent on channel 0). Edges on the other two trigger inputs start nothing.
- R5: With repeat set and a non-zero timing, bit 0 stays 1 after a run and the next selected edge starts a new run. Each start reloads the count, source and destination from their registers. With timing 00 the repeat bit has no effect.
- R6: A trigger edge that arrives while a run is in progress adds no words and is not kept for later.
- R7: A control write with bit 0 at 0 in the same cycle as a trigger edge starts no run and leaves the channel idle with bit 0 at 0. The channel can later be started normally.
- R8: Clearing bit 0 during a run lets the word in flight finish and then returns to idle without reading another word. There is no interrupt unless that word was the last one.
- R9: On an armed idle channel, writing bit 0 = 1, timing 00 and repeat 0 while keeping the other bits runs exactly one more transfer. Afterwards the readback equals the written word with only bit 0 cleared, so bits 15:4 are kept.
- R10: When control bit 4 is set, the interrupt output pulses high for exactly one cycle, in the cycle after the last word's write is acknowledged. When bit 4 is clear it stays low.
- R11: Busy rises in the cycle after the start and stays high until the last word's write acknowledge (or the abort of R8). It is low in the cycle after that acknowledge.
- R12: On channel 3, control bit 5 makes each word wait for the cartridge request input to be high before its read. On other channels bit 5 is stored but has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word value |
| cnt_we | input | 1 | Word count register write strobe |
| cnt_wdata | input | CNT_W | Word count value (0 = maximum) |
| src_we | input | 1 | Source address register write strobe |
| src_wdata | input | ADDR_W | Source start address |
| dst_we | input | 1 | Destination address register write strobe |
| dst_wdata | input | ADDR_W | Destination start address |
| hblank_i | input | 1 | Horizontal blank trigger (edge used) |
| vblank_i | input | 1 | Vertical blank trigger (edge used) |
| special_req_i | input | 1 | Per-channel special request (edge used) |
| cart_req_i | input | 1 | Cartridge data-ready level (channel 3 only) |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | DATA_W | Read data |
| mem_wr_req | output | 1 | Write request |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| ctrl_o | output | 16 | Current control word |
| busy_o | output | 1 | Run in progress |
| irq_o | output | 1 | End-of-run interrupt pulse |

## Verification
The bench builds the main instance with CNT_W=3, ADDR_W=8, DATA_W=8 and CHAN_ID=3. The 3-bit count puts every count, including the 0-means-eight wrap, into one sweep. That sweep covers all four timing codes, all four address-hold combinations, both repeat settings and both acknowledge patterns (zero and one wait state). A second instance with CHAN_ID=1 uses the same small sizes and shows that the cartridge-request bit has no effect off channel 3. Collision, mid-run disable, forced final run and late-trigger cases are then driven at exact cycles on the small instance.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    TM_NOW = 2'b00,
    TM_HBL = 2'b01,
    TM_VBL = 2'b10,
    TM_SPC = 2'b11
  } timing_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_RD,
    SQ_WR
  } seq_e;

  // Control word: spare[15:8] dhold[7] shold[6] cart[5] irq_en[4] rep[3] tm[2:1] en[0]
  typedef struct packed {
    logic [7:0] spare;
    logic       dhold;
    logic       shold;
    logic       cart;
    logic       irq_en;
    logic       rep;
    timing_e    tm;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = 16;

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  input  logic  self_clr,
  output ctrl_t ctrl_q,
  output ctrl_t ctrl_nx
);

  // The value the register will hold after this edge; the start
  // decision looks at it so a same-cycle CPU clear always wins.
  always_comb begin
    ctrl_nx = ctrl_q;
    if (wr_en) begin
      ctrl_nx = wr_val;
    end else if (self_clr) begin
      ctrl_nx.en = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
    end
  end

endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dma_chan_pkg::*;
#(
  parameter int CHAN_ID = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    hblank_i,
  input  logic    vblank_i,
  input  logic    special_i,
  input  timing_e tm,
  output logic    hit
);

  localparam bit HAS_SPECIAL = (CHAN_ID != 0);

  logic [2:0] cur;
  logic [2:0] prev_q;
  logic [2:0] edg;
  logic       spc_edge;

  assign cur = {special_i, vblank_i, hblank_i};
  assign edg = cur & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
    end else begin
      prev_q <= cur;
    end
  end

  generate
    if (HAS_SPECIAL) begin : g_spc
      assign spc_edge = edg[2];
    end else begin : g_nospc
      assign spc_edge = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (tm)
      TM_NOW:  hit = 1'b1;
      TM_HBL:  hit = edg[0];
      TM_VBL:  hit = edg[1];
      TM_SPC:  hit = spc_edge;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_chan_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              en_now,
  input  logic              gated,
  input  logic              cart_req,
  input  logic              shold,
  input  logic              dhold,
  input  logic [CNT_W-1:0]  cnt_ld,
  input  logic [ADDR_W-1:0] src_ld,
  input  logic [ADDR_W-1:0] dst_ld,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              finish
);

  localparam int RW = CNT_W + 1;
  localparam logic [RW-1:0] MAX_CNT = {1'b1, {CNT_W{1'b0}}};

  seq_e              state_q;
  logic [RW-1:0]     remain_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [DATA_W-1:0] data_q;

  assign finish = (state_q == SQ_WR) && wr_ack && (remain_q == RW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      remain_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      data_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            remain_q <= (cnt_ld == '0) ? MAX_CNT : RW'(cnt_ld);
            src_q    <= src_ld;
            dst_q    <= dst_ld;
            state_q  <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (!en_now) begin
            state_q <= SQ_IDLE;
          end else if (!gated || cart_req) begin
            state_q <= SQ_RD;
          end
        end
        SQ_RD: begin
          if (rd_ack) begin
            data_q  <= rd_data;
            state_q <= SQ_WR;
          end
        end
        SQ_WR: begin
          if (wr_ack) begin
            remain_q <= remain_q - 1'b1;
            if (!shold) src_q <= src_q + 1'b1;
            if (!dhold) dst_q <= dst_q + 1'b1;
            state_q <= (remain_q == RW'(1)) ? SQ_IDLE : SQ_WAIT;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != SQ_IDLE);
  assign rd_req  = (state_q == SQ_RD);
  assign wr_req  = (state_q == SQ_WR);
  assign rd_addr = src_q;
  assign wr_addr = dst_q;
  assign wr_data = data_q;

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_chan_pkg::*;
#(
  parameter int CHAN_ID = 3,
  parameter int CNT_W   = 14,
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [15:0]       ctrl_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              src_we,
  input  logic [ADDR_W-1:0] src_wdata,
  input  logic              dst_we,
  input  logic [ADDR_W-1:0] dst_wdata,
  input  logic              hblank_i,
  input  logic              vblank_i,
  input  logic              special_req_i,
  input  logic              cart_req_i,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic [15:0]       ctrl_o,
  output logic              busy_o,
  output logic              irq_o
);

  localparam bit HAS_CART = (CHAN_ID == 3);

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_nx;
  ctrl_t             ctrl_wv;
  logic              self_clr;
  logic              hit;
  logic              start;
  logic              busy;
  logic              finish;
  logic              gated;
  logic              irq_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;

  assign ctrl_wv = ctrl_t'(ctrl_wdata);

  // Transfer setup registers, sampled at each start
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      if (cnt_we) cnt_q <= cnt_wdata;
      if (src_we) src_q <= src_wdata;
      if (dst_we) dst_q <= dst_wdata;
    end
  end

  // Self clear unless a repeating, trigger-driven run just ended
  assign self_clr = finish && !(ctrl_q.rep && (ctrl_q.tm != TM_NOW));

  dma_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctrl_we),
    .wr_val   (ctrl_wv),
    .self_clr (self_clr),
    .ctrl_q   (ctrl_q),
    .ctrl_nx  (ctrl_nx)
  );

  dma_trig_sel #(.CHAN_ID(CHAN_ID)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .hblank_i  (hblank_i),
    .vblank_i  (vblank_i),
    .special_i (special_req_i),
    .tm        (ctrl_nx.tm),
    .hit       (hit)
  );

  assign start = !busy && ctrl_nx.en && hit;

  generate
    if (HAS_CART) begin : g_cart
      assign gated = ctrl_q.cart;
    end else begin : g_nocart
      assign gated = 1'b0;
    end
  endgenerate

  dma_xfer_seq #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .en_now   (ctrl_q.en),
    .gated    (gated),
    .cart_req (cart_req_i),
    .shold    (ctrl_q.shold),
    .dhold    (ctrl_q.dhold),
    .cnt_ld   (cnt_q),
    .src_ld   (src_q),
    .dst_ld   (dst_q),
    .rd_ack   (mem_rd_ack),
    .rd_data  (mem_rd_data),
    .wr_ack   (mem_wr_ack),
    .busy     (busy),
    .rd_req   (mem_rd_req),
    .rd_addr  (mem_rd_addr),
    .wr_req   (mem_wr_req),
    .wr_addr  (mem_wr_addr),
    .wr_data  (mem_wr_data),
    .finish   (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= finish && ctrl_q.irq_en;
    end
  end

  assign ctrl_o = ctrl_q;
  assign busy_o = busy;
  assign irq_o  = irq_q;

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_we,
  input logic [15:0]       ctrl_wdata,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic [15:0]       ctrl_o,
  input logic              busy_o,
  input logic              irq_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ctrl_o == 16'h0 && !busy_o && !irq_o && !mem_rd_req && !mem_wr_req));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R2
  no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  // R3
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !$past(ctrl_we) && (!$past(ctrl_o[3]) || $past(ctrl_o[2:1]) == 2'b00))
    |-> !ctrl_o[0]);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ctrl_o[0] && !(mem_wr_req && mem_wr_ack)) |=> busy_o);

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !ctrl_wdata[0] && !busy_o) |=> (!busy_o && !ctrl_o[0]));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R11
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> busy_o);

endmodule

bind dma_channel dma_channel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_we     (ctrl_we),
  .ctrl_wdata  (ctrl_wdata),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_ack  (mem_rd_ack),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_ack  (mem_wr_ack),
  .ctrl_o      (ctrl_o),
  .busy_o      (busy_o),
  .irq_o       (irq_o)
);

// File: tb/dma_channel_test.sv
module dma_channel_test;

  localparam int CW = 3;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // main instance signals
  logic          ctrl_we = 0;
  logic [15:0]   ctrl_wdata = '0;
  logic          cnt_we = 0, src_we = 0, dst_we = 0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [AW-1:0] src_wdata = '0, dst_wdata = '0;
  logic          hblank = 0, vblank = 0, special = 0, cart_req = 1;
  logic          rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_ack = 0, wr_ack = 0;
  logic [DW-1:0] rd_data = '0;
  logic [15:0]   ctrl_o;
  logic          busy, irq;

  // channel-1 instance signals
  logic          c1_ctrl_we = 0;
  logic [15:0]   c1_ctrl_wdata = '0;
  logic          c1_rd_req, c1_wr_req, c1_busy, c1_irq;
  logic [AW-1:0] c1_rd_addr, c1_wr_addr;
  logic [DW-1:0] c1_wr_data;
  logic [15:0]   c1_ctrl_o;
  int            c1_writes = 0;

  int nvec = 0, nmis = 0, cycles = 0;

  // memory model state
  int            widx = 0, nwords = 0, irq_seen = 0;
  logic [AW-1:0] sbase = '0, dbase = '0;
  bit            sh = 0, dh = 0, ws_mode = 0, ws_tog = 0, pend_end = 0, exp_irq = 0, ph_ok;

  dma_channel #(.CHAN_ID(3), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .src_we(src_we), .src_wdata(src_wdata),
    .dst_we(dst_we), .dst_wdata(dst_wdata), .hblank_i(hblank), .vblank_i(vblank),
    .special_req_i(special), .cart_req_i(cart_req),
    .mem_rd_req(rd_req), .mem_rd_addr(rd_addr), .mem_rd_ack(rd_ack), .mem_rd_data(rd_data),
    .mem_wr_req(wr_req), .mem_wr_addr(wr_addr), .mem_wr_data(wr_data), .mem_wr_ack(wr_ack),
    .ctrl_o(ctrl_o), .busy_o(busy), .irq_o(irq)
  );

  dma_channel #(.CHAN_ID(1), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) uut_c1 (
    .clk(clk), .rst(rst), .ctrl_we(c1_ctrl_we), .ctrl_wdata(c1_ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .src_we(src_we), .src_wdata(src_wdata),
    .dst_we(dst_we), .dst_wdata(dst_wdata), .hblank_i(1'b0), .vblank_i(1'b0),
    .special_req_i(1'b0), .cart_req_i(1'b0),
    .mem_rd_req(c1_rd_req), .mem_rd_addr(c1_rd_addr), .mem_rd_ack(c1_rd_req), .mem_rd_data(8'h11),
    .mem_wr_req(c1_wr_req), .mem_wr_addr(c1_wr_addr), .mem_wr_data(c1_wr_data), .mem_wr_ack(c1_wr_req),
    .ctrl_o(c1_ctrl_o), .busy_o(c1_busy), .irq_o(c1_irq)
  );

  function automatic logic [DW-1:0] f(logic [AW-1:0] a);
    return DW'(a * 5 + 3);
  endfunction

  function automatic logic [15:0] mk(bit en, int tm, bit rep, bit ie, bit cart, bit shh, bit dhh);
    return {8'h5A, dhh, shh, cart, ie, rep, 2'(tm), en};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Memory model and word-by-word checks, all at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (pend_end) begin
        chk(busy == 1'b0, "R11 busy low after last write", int'(busy), 0);
        chk(irq == exp_irq, "R10 irq after last write", int'(irq), int'(exp_irq));
        pend_end = 0;
      end
      if (irq) irq_seen++;
      if (c1_wr_req) c1_writes++;
      ws_tog = ~ws_tog;
      ph_ok  = !ws_mode || ws_tog;
      rd_ack = rd_req && ph_ok;
      rd_data = rd_ack ? f(rd_addr) : '0;
      wr_ack = wr_req && ph_ok;
      if (wr_ack) begin
        chk(wr_addr == AW'(dbase + AW'(dh ? 0 : widx)), "R2 destination address",
            int'(wr_addr), int'(AW'(dbase + AW'(dh ? 0 : widx))));
        chk(wr_data == f(AW'(sbase + AW'(sh ? 0 : widx))), "R2 word data",
            int'(wr_data), int'(f(AW'(sbase + AW'(sh ? 0 : widx)))));
        widx++;
        if (widx == nwords) pend_end = 1;
        else chk(busy == 1'b1, "R11 busy during run", int'(busy), 1);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [15:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic setup(int n, logic [AW-1:0] s, logic [AW-1:0] d);
    cnt_we = 1; src_we = 1; dst_we = 1;
    cnt_wdata = CW'(n); src_wdata = s; dst_wdata = d;
    @(negedge clk);
    cnt_we = 0; src_we = 0; dst_we = 0;
  endtask

  task automatic prep(int n, logic [AW-1:0] s, logic [AW-1:0] d, bit shh, bit dhh, bit ie);
    widx = 0; nwords = n; irq_seen = 0; exp_irq = ie;
    sbase = s; dbase = d; sh = shh; dh = dhh;
  endtask

  task automatic pulse(int which);
    case (which)
      1: hblank = 1;
      2: vblank = 1;
      default: special = 1;
    endcase
    @(negedge clk);
    hblank = 0; vblank = 0; special = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (busy && k < 300) begin
      @(negedge clk);
      k++;
    end
    if (k >= 300) chk(0, "R11 run never ended", k, 300);
    @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nmis++;
      $display("FAIL watchdog (all) act=%0d exp=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    // R1
    chk(ctrl_o == 16'h0, "R1 control after reset", int'(ctrl_o), 0);
    chk(!busy && !irq, "R1 busy/irq after reset", int'(busy) + int'(irq), 0);
    chk(!rd_req && !wr_req, "R1 no requests after reset", int'(rd_req) + int'(wr_req), 0);

    // Sweep: every count, timing code, hold pattern
    for (int n = 0; n < 8; n++) begin
      for (int tm = 0; tm < 4; tm++) begin
        for (int h = 0; h < 4; h++) begin
          int words;
          bit rep, ie, shh, dhh, keep;
          logic [AW-1:0] s, d;
          words = (n == 0) ? 8 : n;
          rep = bit'(n % 2);
          ie  = bit'((n + h) % 2);
          shh = bit'(h % 2);
          dhh = bit'(h / 2);
          keep = (tm != 0) && rep;
          ws_mode = bit'((tm + h) % 2);
          s = AW'(n * 16 + h * 3);
          d = AW'(200 - n * 7 - tm);
          setup(n, s, d);
          prep(words, s, d, shh, dhh, ie);
          if (tm == 0) begin
            wr_ctrl(mk(1, 0, rep, ie, 0, shh, dhh));
            chk(busy == 1'b1, "R4 immediate start next cycle", int'(busy), 1);
          end else begin
            wr_ctrl(mk(1, tm, rep, ie, 0, shh, dhh));
            for (int w = 1; w < 4; w++) if (w != tm) pulse(w);
            cyc(2);
            chk(!busy && widx == 0, "R4 other triggers ignored", widx, 0);
            pulse(tm);
            chk(busy == 1'b1, "R4 selected trigger starts", int'(busy), 1);
          end
          wait_idle();
          chk(widx == words, "R2 words per run", widx, words);
          if (keep) chk(ctrl_o[0] == 1'b1, "R5 stays enabled", int'(ctrl_o[0]), 1);
          else      chk(ctrl_o[0] == 1'b0, "R3 enable self-cleared", int'(ctrl_o[0]), 0);
          chk(irq_seen == int'(ie), "R10 irq pulse count", irq_seen, int'(ie));
          if (keep) begin
            setup(n, s, AW'(d + 1));
            prep(words, s, AW'(d + 1), shh, dhh, ie);
            pulse(tm);
            wait_idle();
            chk(widx == words, "R5 rerun reloads", widx, words);
            wr_ctrl(mk(0, tm, rep, ie, 0, shh, dhh));
            chk(ctrl_o[0] == 1'b0 && !busy, "R7 clean disable when idle", int'(ctrl_o[0]), 0);
          end
        end
      end
    end
    ws_mode = 0;

    // R6: triggers during a run are dropped
    setup(5, 8'h10, 8'h80);
    prep(5, 8'h10, 8'h80, 0, 0, 0);
    wr_ctrl(mk(1, 1, 1, 0, 0, 0, 0));
    pulse(1);
    cyc(2);
    pulse(1);
    cyc(1);
    pulse(1);
    wait_idle();
    chk(widx == 5, "R6 no extra words", widx, 5);
    cyc(10);
    chk(!busy && widx == 5, "R6 trigger not queued", widx, 5);
    wr_ctrl(mk(0, 1, 1, 0, 0, 0, 0));

    // R7: disable write collides with trigger
    setup(3, 8'h20, 8'h90);
    prep(3, 8'h20, 8'h90, 0, 0, 1);
    wr_ctrl(mk(1, 1, 1, 1, 0, 0, 0));
    ctrl_we = 1; ctrl_wdata = mk(0, 1, 1, 1, 0, 0, 0); hblank = 1;
    @(negedge clk);
    ctrl_we = 0; hblank = 0;
    chk(busy == 1'b0, "R7 clear beats trigger", int'(busy), 0);
    cyc(5);
    chk(widx == 0 && ctrl_o[0] == 1'b0, "R7 stays idle", widx, 0);
    wr_ctrl(mk(1, 1, 0, 1, 0, 0, 0));
    pulse(1);
    wait_idle();
    chk(widx == 3, "R7 channel recovers", widx, 3);

    // R8: disable during a run
    setup(0, 8'h30, 8'hA0);
    prep(8, 8'h30, 8'hA0, 0, 0, 1);
    wr_ctrl(mk(1, 0, 0, 1, 0, 0, 0));
    cyc(6);
    wr_ctrl(mk(0, 0, 0, 1, 0, 0, 0));
    wait_idle();
    chk(widx >= 1 && widx < 8, "R8 run cut short", widx, 4);
    chk(irq_seen == 0, "R8 no irq on abort", irq_seen, 0);
    chk(ctrl_o[0] == 1'b0 && !busy, "R8 idle after abort", int'(busy), 0);

    // R9: forced final immediate run
    setup(3, 8'h40, 8'hB0);
    prep(3, 8'h40, 8'hB0, 1, 0, 0);
    wr_ctrl(mk(1, 2, 1, 0, 0, 1, 0));
    cyc(3);
    chk(!busy, "R9 armed idle", int'(busy), 0);
    wr_ctrl(mk(1, 0, 0, 0, 0, 1, 0));
    chk(busy == 1'b1, "R9 final run starts", int'(busy), 1);
    wait_idle();
    chk(widx == 3, "R9 one run", widx, 3);
    chk(ctrl_o == mk(0, 0, 0, 0, 0, 1, 0), "R9 other bits kept",
        int'(ctrl_o), int'(mk(0, 0, 0, 0, 0, 1, 0)));
    cyc(10);
    chk(widx == 3 && !busy, "R9 no further run", widx, 3);

    // R12: cartridge gating on channel 3
    setup(2, 8'h50, 8'hC0);
    prep(2, 8'h50, 8'hC0, 0, 0, 0);
    cart_req = 0;
    wr_ctrl(mk(1, 0, 0, 0, 1, 0, 0));
    cyc(8);
    chk(widx == 0 && busy, "R12 waits for cart request", widx, 0);
    cart_req = 1;
    wait_idle();
    chk(widx == 2, "R12 completes once released", widx, 2);

    // R12: bit ignored on channel 1
    c1_writes = 0;
    c1_ctrl_we = 1; c1_ctrl_wdata = mk(1, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    c1_ctrl_we = 0;
    cyc(20);
    chk(c1_writes == 2, "R12 channel 1 ignores cart bit", c1_writes, 2);
    chk(!c1_busy && c1_ctrl_o[0] == 1'b0, "R12 channel 1 finished", int'(c1_busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

endmodule